// File: doc/BRIEF.md
# Chromosome Fault Recovery Unit

This unit sits in front of a processing element of a cellular genetic algorithm and cleans up the neighbour chromosomes it is about to use. Each neighbour arrives as a protected codeword: data bits followed by a CRC check field. The unit takes one codeword per request and computes the CRC syndrome. If the syndrome is zero, the unit returns the data field as it is. If the syndrome is nonzero, the unit does not discard the word. It breeds a replacement in a short local evolutionary step that uses the damaged data, the best genotype of the previous generation, one single-bit mutant of each, and one single-point crossover between the two weakest candidates.

Fitness is always recomputed from the genotype inside the unit, so a corrupted stored score can never steer the repair. The mutation and crossover positions come from an internal 16-bit LFSR. This LFSR is reloaded from a seed input on every accepted request, which makes each repair reproducible for a given seed. A request is a single-cycle `start` pulse. The result appears on `repaired` together with a one-cycle `done` pulse. Healthy words finish in two cycles and repaired words in four.

Top module: `chrom_repair`

## Requirements
- R1: After reset, `done` is 0 and `repaired` is all zeros.
- R2: The codeword is {data[8:4], check[3:0]}. The check field is the remainder of data·x^4 divided by x^4+x+1. When a `start` is sampled at clock edge k and the syndrome of the whole codeword is zero, `done` is 1 after edge k+1, and `repaired` then equals the data field.
- R3: When the syndrome is nonzero, `done` is 1 after edge k+3 and not earlier. Any corruption of one or two codeword bits takes this path.
- R4: The repair candidates are, in order, C1 = damaged data field, C2 = C1 with bit (L[3:0] mod 5) inverted, C3 = `good_geno`, and C4 = C3 with bit (L[7:4] mod 5) inverted. L is the LFSR value loaded at the request.
- R5: On an accepted `start`, the LFSR loads `seed`, or 1 if `seed` is zero. It advances once after the syndrome check of a faulty word with next = {q[14:0], q[15]^q[13]^q[12]^q[10]}, and it is never zero.
- R6: Fitness is x·x, where the chromosome is read as a 5-bit two's-complement integer x. Lower is better. Candidates are ranked by fitness, and equal fitness keeps the earlier candidate ahead.
- R7: The candidates ranked third (A) and fourth (B) are crossed at cut c = (L'[3:0] mod 4) + 1, where L' is the advanced LFSR value. With low = 2^c − 1, child1 = (A & ~low) | (B & low) and child2 = (B & ~low) | (A & low).
- R8: The result is the fittest of child1, child2, the best candidate and the second-best candidate, with ties going to the earlier of these in that order.
- R9: A `start` that arrives while a request is in progress is ignored. It causes no extra `done` and does not change the result.
- R10: `done` is high for exactly one cycle per request, and `repaired` holds its value until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted only when idle |
| codeword | input | 9 | Neighbour data field and CRC check field |
| good_geno | input | 5 | Best genotype of the previous generation |
| seed | input | 16 | LFSR load value for this request |
| done | output | 1 | One-cycle completion strobe |
| repaired | output | 5 | Repaired or passed-through chromosome |

## Verification
All 32 data values are encoded and sent through the clean path. This separates correct pass-through and two-cycle latency from any wrongful repair. Single-bit corruptions at every codeword position are swept against several good genotypes and seeds, including a zero seed. Because each corruption places the damaged word, the mutants and the crossover parents in different rank orders, this sweep exposes errors in mutation position, ranking, tie handling, cut point and final pick. A full sweep of two-bit corruptions confirms that every double error takes the repair path. A second `start` injected mid-repair must leave both the result and the number of `done` pulses unchanged.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
   localparam int NUM_CAND = 4;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CHECK = 2'd1,
      ST_RANK  = 2'd2,
      ST_PICK  = 2'd3
   } rep_state_t;
endpackage

// File: rtl/cfr_crc_check.sv
module cfr_crc_check #(
   parameter int DATA_W = 5,
   parameter int CRC_W  = 4,
   parameter logic [CRC_W-1:0] POLY = 4'h3
) (
   input  logic [DATA_W+CRC_W-1:0] cw,
   output logic [CRC_W-1:0]        syn
);
   localparam int CW_W = DATA_W + CRC_W;

   if (CRC_W < 2) begin : g_bad_crc
      $error("cfr_crc_check: CRC_W must be at least 2");
   end

   always_comb begin
      logic [CRC_W-1:0] r;
      logic fb;
      r = '0;
      for (int i = CW_W - 1; i >= 0; i--) begin
         fb = r[CRC_W-1] ^ cw[i];
         r  = {r[CRC_W-2:0], 1'b0};
         if (fb) r = r ^ POLY;
      end
      syn = r;
   end
endmodule

// File: rtl/cfr_lfsr.sv
module cfr_lfsr #(
   parameter int W = 16,
   parameter logic [W-1:0] TAPS = 16'hB400
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] seed,
   input  logic         step,
   output logic [W-1:0] q
);
   if (W < 8) begin : g_bad_w
      $error("cfr_lfsr: W must be at least 8");
   end

   logic fb;
   assign fb = ^(q & TAPS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= W'(1);
      end else if (load) begin
         q <= (seed == '0) ? W'(1) : seed;
      end else if (step) begin
         q <= {q[W-2:0], fb};
      end
   end
endmodule

// File: rtl/cfr_fitness.sv
module cfr_fitness #(
   parameter int DATA_W = 5
) (
   input  logic [DATA_W-1:0]   geno,
   output logic [2*DATA_W-1:0] fit
);
   localparam int FW = 2 * DATA_W;

   logic signed [FW-1:0] ext;
   logic signed [FW-1:0] sq;

   assign ext = FW'(signed'(geno));
   assign sq  = ext * ext;
   assign fit = $unsigned(sq);
endmodule

// File: rtl/cfr_rank.sv
module cfr_rank #(
   parameter int DATA_W = 5,
   parameter int N      = 4
) (
   input  logic [N-1:0][DATA_W-1:0]   cand,
   output logic [N-1:0][DATA_W-1:0]   sorted,
   output logic [N-1:0][2*DATA_W-1:0] sorted_fit
);
   localparam int FW = 2 * DATA_W;
   localparam int RW = $clog2(N);

   if (N < 2) begin : g_bad_n
      $error("cfr_rank: N must be at least 2");
   end

   logic [N-1:0][FW-1:0] fit;
   logic [RW-1:0]        rnk [N];

   for (genvar gi = 0; gi < N; gi++) begin : g_fit
      cfr_fitness #(.DATA_W(DATA_W)) u_fit (
         .geno (cand[gi]),
         .fit  (fit[gi])
      );
   end

   // stable rank: count strictly better entries, plus equal entries placed earlier
   always_comb begin
      for (int i = 0; i < N; i++) begin
         rnk[i] = '0;
         for (int j = 0; j < N; j++) begin
            if (j != i) begin
               if ((fit[j] < fit[i]) || ((fit[j] == fit[i]) && (j < i))) begin
                  rnk[i] = rnk[i] + RW'(1);
               end
            end
         end
      end
   end

   always_comb begin
      sorted     = '0;
      sorted_fit = '0;
      for (int k = 0; k < N; k++) begin
         for (int i = 0; i < N; i++) begin
            if (rnk[i] == RW'(k)) begin
               sorted[k]     = cand[i];
               sorted_fit[k] = fit[i];
            end
         end
      end
   end
endmodule

// File: rtl/chrom_repair.sv
module chrom_repair #(
   parameter int DATA_W = 5,
   parameter int CRC_W  = 4,
   parameter logic [CRC_W-1:0] POLY = 4'h3,
   parameter int LFSR_W = 16,
   parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [DATA_W+CRC_W-1:0] codeword,
   input  logic [DATA_W-1:0]       good_geno,
   input  logic [LFSR_W-1:0]       seed,
   output logic                    done,
   output logic [DATA_W-1:0]       repaired
);
   import cfr_pkg::*;

   localparam int CW_W  = DATA_W + CRC_W;
   localparam int FW    = 2 * DATA_W;
   localparam int IDX_W = $clog2(DATA_W);
   localparam int SEL_W = IDX_W + 1;

   if (DATA_W < 3) begin : g_bad_data
      $error("chrom_repair: DATA_W must be at least 3");
   end
   if (LFSR_W < 2 * SEL_W) begin : g_bad_lfsr
      $error("chrom_repair: LFSR_W too narrow for two position fields");
   end

   rep_state_t state;

   logic [CW_W-1:0]                    cw_q;
   logic [DATA_W-1:0]                  good_q;
   logic [NUM_CAND-1:0][DATA_W-1:0]    cand_q;
   logic [NUM_CAND-1:0][DATA_W-1:0]    fin_q;
   logic [DATA_W-1:0]                  res_q;
   logic                               done_q;

   logic [CRC_W-1:0]                   syn;
   logic [LFSR_W-1:0]                  rnd;
   logic [DATA_W-1:0]                  cw_data;
   logic [IDX_W-1:0]                   pos_a, pos_b, cut;
   logic [DATA_W-1:0]                  flip_a, flip_b, low_mask;
   logic [DATA_W-1:0]                  par_a, par_b, child1, child2;
   logic [NUM_CAND-1:0][DATA_W-1:0]    sorted_c, sorted_f;
   logic [NUM_CAND-1:0][FW-1:0]        fit_c, fit_f;
   logic                               lfsr_load, lfsr_step, faulty;

   assign cw_data = cw_q[CW_W-1:CRC_W];
   assign faulty  = (syn != '0);

   cfr_crc_check #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY)) u_check (
      .cw  (cw_q),
      .syn (syn)
   );

   assign lfsr_load = (state == ST_IDLE) && start;
   assign lfsr_step = (state == ST_CHECK) && faulty;

   cfr_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS)) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (lfsr_load),
      .seed  (seed),
      .step  (lfsr_step),
      .q     (rnd)
   );

   // mutation positions and crossover cut taken from LFSR fields
   always_comb begin
      pos_a    = IDX_W'(32'(rnd[SEL_W-1:0]) % DATA_W);
      pos_b    = IDX_W'(32'(rnd[2*SEL_W-1:SEL_W]) % DATA_W);
      cut      = IDX_W'((32'(rnd[SEL_W-1:0]) % (DATA_W - 1)) + 1);
      flip_a   = DATA_W'(1) << pos_a;
      flip_b   = DATA_W'(1) << pos_b;
      low_mask = (DATA_W'(1) << cut) - DATA_W'(1);
   end

   cfr_rank #(.DATA_W(DATA_W), .N(NUM_CAND)) u_rank_cand (
      .cand       (cand_q),
      .sorted     (sorted_c),
      .sorted_fit (fit_c)
   );

   always_comb begin
      par_a  = sorted_c[NUM_CAND-2];
      par_b  = sorted_c[NUM_CAND-1];
      child1 = (par_a & ~low_mask) | (par_b & low_mask);
      child2 = (par_b & ~low_mask) | (par_a & low_mask);
   end

   cfr_rank #(.DATA_W(DATA_W), .N(NUM_CAND)) u_rank_final (
      .cand       (fin_q),
      .sorted     (sorted_f),
      .sorted_fit (fit_f)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cw_q   <= '0;
         good_q <= '0;
         cand_q <= '0;
         fin_q  <= '0;
         res_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  cw_q   <= codeword;
                  good_q <= good_geno;
                  state  <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               if (!faulty) begin
                  res_q  <= cw_data;
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end else begin
                  cand_q[0] <= cw_data;
                  cand_q[1] <= cw_data ^ flip_a;
                  cand_q[2] <= good_q;
                  cand_q[3] <= good_q ^ flip_b;
                  state     <= ST_RANK;
               end
            end
            ST_RANK: begin
               fin_q[0] <= child1;
               fin_q[1] <= child2;
               fin_q[2] <= sorted_c[0];
               fin_q[3] <= sorted_c[1];
               state    <= ST_PICK;
            end
            ST_PICK: begin
               res_q  <= sorted_f[0];
               done_q <= 1'b1;
               state  <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign done     = done_q;
   assign repaired = res_q;

   // R2
   healthy_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CHECK && syn == '0) |=> (done && repaired == $past(cw_q[CW_W-1:CRC_W])));

   // R3
   done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(state) == ST_PICK || ($past(state) == ST_CHECK && $past(syn) == '0)));

   // R4
   single_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CHECK && syn != '0) |=>
         ($countones(cand_q[0] ^ cand_q[1]) == 1 && $countones(cand_q[2] ^ cand_q[3]) == 1));

   // R5
   lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rnd != '0);

   // R6
   cand_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RANK) |-> (fit_c[0] <= fit_c[1] && fit_c[1] <= fit_c[2] && fit_c[2] <= fit_c[3]));

   // R8
   final_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PICK) |-> (fit_f[0] <= fit_f[1] && fit_f[1] <= fit_f[2] && fit_f[2] <= fit_f[3]));

   // R9
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && start) |=> $stable(cw_q));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: tb/chrom_repair_test.sv
module chrom_repair_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [8:0]  codeword = '0;
   logic [4:0]  good_geno = '0;
   logic [15:0] seed = '0;
   logic        done;
   logic [4:0]  repaired;

   int tests = 0;
   int fails = 0;

   always #10 clk = ~clk;

   chrom_repair uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .codeword  (codeword),
      .good_geno (good_geno),
      .seed      (seed),
      .done      (done),
      .repaired  (repaired)
   );

   function automatic logic [8:0] encode(input logic [4:0] d);
      logic [8:0] r;
      r = {d, 4'b0000};
      for (int b = 8; b >= 4; b--) begin
         if (r[b]) r = r ^ (9'b1_0011 << (b - 4));
      end
      return {d, r[3:0]};
   endfunction

   function automatic int fitv(input logic [4:0] v);
      int x;
      x = v[4] ? int'(v) - 32 : int'(v);
      return x * x;
   endfunction

   function automatic logic [15:0] lstep(input logic [15:0] q);
      return {q[14:0], q[15] ^ q[13] ^ q[12] ^ q[10]};
   endfunction

   function automatic logic [4:0] model_fix(input logic [4:0] d, input logic [4:0] g,
                                            input logic [15:0] s);
      logic [15:0] l0, l1;
      logic [4:0]  c [4];
      logic [4:0]  fin [4];
      logic [4:0]  low, a, b;
      int idx [4];
      int p1, p2, cut, t, best;
      l0 = (s == 16'h0) ? 16'h1 : s;
      p1 = int'(l0[3:0]) % 5;
      p2 = int'(l0[7:4]) % 5;
      c[0] = d; c[1] = d ^ (5'd1 << p1);
      c[2] = g; c[3] = g ^ (5'd1 << p2);
      l1 = lstep(l0);
      cut = (int'(l1[3:0]) % 4) + 1;
      for (int i = 0; i < 4; i++) idx[i] = i;
      for (int i = 1; i < 4; i++) begin
         for (int j = i; j > 0; j--) begin
            if (fitv(c[idx[j]]) < fitv(c[idx[j-1]])) begin
               t = idx[j]; idx[j] = idx[j-1]; idx[j-1] = t;
            end
         end
      end
      low = 5'((1 << cut) - 1);
      a = c[idx[2]]; b = c[idx[3]];
      fin[0] = (a & ~low) | (b & low);
      fin[1] = (b & ~low) | (a & low);
      fin[2] = c[idx[0]];
      fin[3] = c[idx[1]];
      best = 0;
      for (int i = 1; i < 4; i++) if (fitv(fin[i]) < fitv(fin[best])) best = i;
      return fin[best];
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic request(input logic [8:0] cw, input logic [4:0] g, input logic [15:0] s,
                          input logic [4:0] exp, input int exp_lat, input string req);
      int n;
      @(negedge clk);
      codeword = cw; good_geno = g; seed = s; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 1;
      while (!done && n < 20) begin
         @(negedge clk);
         n++;
      end
      check(n == exp_lat, {req, " latency"}, n, exp_lat);
      check(repaired == exp, {req, " value"}, int'(repaired), int'(exp));
      @(negedge clk);
      check(!done, "R10 pulse", int'(done), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [4:0]  goods [4];
      logic [15:0] seeds [3];
      logic [8:0]  bad;
      logic [4:0]  held;
      int n, dcount;
      goods[0] = 5'd0; goods[1] = 5'd3; goods[2] = 5'd16; goods[3] = 5'd29;
      seeds[0] = 16'h0000; seeds[1] = 16'hACE1; seeds[2] = 16'h3C5F;

      repeat (3) @(negedge clk);
      // R1 reset state
      check(done == 1'b0, "R1 done", int'(done), 0);
      check(repaired == 5'd0, "R1 repaired", int'(repaired), 0);
      rst_n = 1'b1;

      // R2 clean words for every data value
      for (int d = 0; d < 32; d++) begin
         request(encode(5'(d)), 5'(31 - d), 16'h1234, 5'(d), 2, "R2");
      end

      // R3 R4 R5 R6 R7 R8 single-bit corruption sweep
      for (int d = 0; d < 32; d++) begin
         for (int gi = 0; gi < 4; gi++) begin
            for (int si = 0; si < 3; si++) begin
               bad = encode(5'(d)) ^ (9'd1 << ((d + gi + si) % 9));
               request(bad, goods[gi], seeds[si],
                       model_fix(bad[8:4], goods[gi], seeds[si]), 4, "R8 repair");
            end
         end
      end

      // R3 every double-bit corruption takes the repair path
      for (int i = 0; i < 9; i++) begin
         for (int j = i + 1; j < 9; j++) begin
            bad = encode(5'd13) ^ (9'd1 << i) ^ (9'd1 << j);
            request(bad, 5'd2, 16'h0F0F, model_fix(bad[8:4], 5'd2, 16'h0F0F), 4, "R3 double");
         end
      end

      // R9 start during a repair is ignored
      bad = encode(5'd21) ^ 9'd1;
      @(negedge clk);
      codeword = bad; good_geno = 5'd7; seed = 16'h5A5A; start = 1'b1;
      @(negedge clk);
      codeword = encode(5'd9); good_geno = 5'd0; seed = 16'h0001;
      n = 1;
      @(negedge clk);
      start = 1'b0;
      n = 2;
      while (!done && n < 20) begin
         @(negedge clk);
         n++;
      end
      check(n == 4, "R9 latency", n, 4);
      check(repaired == model_fix(bad[8:4], 5'd7, 16'h5A5A), "R9 value",
            int'(repaired), int'(model_fix(bad[8:4], 5'd7, 16'h5A5A)));
      held = repaired;
      dcount = 0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         if (done) dcount++;
      end
      check(dcount == 0, "R9 extra done", dcount, 0);
      // R10 result holds between requests
      check(repaired == held, "R10 hold", int'(repaired), int'(held));

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule